// File: doc/BRIEF.md
# Keypad Event Queue with Indexed Peek

This block holds keypad events until a host collects them. Each event arrives as a 7-bit key code plus a flag that tells a release from a press. The block packs the pair into one byte and appends it to a circular store of `DEPTH` bytes. The store is addressed by a start pointer and a fill count. The host has two ways to read. A consuming read steps the start pointer forward and returns the byte it lands on. A peek returns the byte at any offset from the start pointer and leaves the queue as it is.

Toward the surrounding status logic, the block gives a one-cycle pulse for each accepted event and a pulse for each event dropped because the store is full. It also keeps a sticky overflow bit that only the status logic clears. The status logic returns its error-summary flag as `err_flag`. While that flag and the overflow bit are both set, incoming events are ignored completely. A `clear` input empties the queue in a single cycle.

The consuming read never returns the oldest byte held, at index start. It returns the byte after it, so one byte always stays behind as the previously serviced event. Peek offset 0 shows that byte. `DEPTH` must be a power of two.

Top module: `keyevt_queue`

## Requirements
- R1: A stored byte holds the key code in bits 6:0 and the release flag in bit 7, so release=1 gives bit 7 = 1.
- R2: When `fill_level` < DEPTH, an accepted event is written at slot (start + fill) mod DEPTH. `key_seen` is high in that same cycle, and `fill_level` rises by one after the edge unless a consuming read also takes effect.
- R3: An event that arrives with `fill_level` = DEPTH, while not locked out, is dropped. The stored bytes do not change, `ovf_seen` pulses in that cycle, and `ovf_bit` reads 1 from the next cycle on.
- R4: While `err_flag` and `ovf_bit` are both 1, an incoming event changes nothing: no `key_seen`, no `ovf_seen`, and no change to the fill level or the stored bytes.
- R5: `ovf_bit` stays set until `err_clr` is applied and reads 0 in the cycle after. If an overflow happens in the same cycle as `err_clr`, the overflow wins.
- R6: A consuming read with `fill_level` <= 1 returns 0x00 on `pop_data` and changes neither the pointers nor the fill level.
- R7: A consuming read with `fill_level` >= 2 shows, in that cycle, the byte at slot (start + 1) mod DEPTH. After the edge the start pointer moves to that slot and the fill level drops by one.
- R8: `peek_data` is the byte at slot (start + `peek_off`) mod DEPTH when `peek_off` < `fill_level`, and 0x00 otherwise. Peeking never changes the queue.
- R9: `clear` sets the start pointer and fill level to 0 at the next edge. It overrides a simultaneous event, which is then neither stored nor reported, and a simultaneous consuming read.
- R10: An accepted event and an effective consuming read in the same cycle are both carried out, and `fill_level` is unchanged.
- R11: After reset the fill level is 0, `ovf_bit` is 0, and every peek and consuming read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Empty the queue at the next edge |
| evt_valid | input | 1 | A key event is offered this cycle |
| evt_code | input | 7 | Key code of the offered event |
| evt_release | input | 1 | 1 = release, 0 = press |
| err_flag | input | 1 | Error-summary flag from the status logic |
| err_clr | input | 1 | Clears the sticky overflow bit |
| pop_req | input | 1 | Consuming read strobe |
| pop_data | output | 8 | Byte returned by the consuming read this cycle |
| peek_off | input | $clog2(DEPTH)+1 | Peek offset from the start pointer |
| peek_data | output | 8 | Byte at the peek offset, or 0x00 |
| key_seen | output | 1 | Pulse: event accepted this cycle |
| ovf_seen | output | 1 | Pulse: event dropped because the queue was full |
| ovf_bit | output | 1 | Sticky overflow error bit |
| fill_level | output | $clog2(DEPTH+1) | Number of bytes held |

## Verification
The bench builds the block with the default DEPTH of 16. At that size every slot, every fill level from 0 to full, and several wraps of the start pointer can be reached in a few hundred cycles. `peek_off` is five bits wide, so each sweep covers every offset, including all offsets at or beyond the fill level. The sweep then compares every stored byte against a ring model that the bench computes with plain modular arithmetic.

// File: rtl/keyevt_pkg.sv
`timescale 1ns/1ps
package keyevt_pkg;
  localparam int KEY_CODE_W = 7;
  localparam int KEY_BYTE_W = KEY_CODE_W + 1;

  // slot reached from a base pointer after a given offset on the ring
  function automatic int unsigned ring_slot(input int unsigned base,
                                            input int unsigned off,
                                            input int unsigned depth);
    return (base + off) % depth;
  endfunction

  // release flag in the top bit, key code below it
  function automatic logic [KEY_BYTE_W-1:0] pack_key(input logic [KEY_CODE_W-1:0] code,
                                                     input logic rel);
    return {rel, code};
  endfunction
endpackage

// File: rtl/keyevt_ring_ctrl.sv
`timescale 1ns/1ps
module keyevt_ring_ctrl
  import keyevt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             evt_valid,
  input  logic             pop_req,
  input  logic             err_flag,
  input  logic             err_clr,
  output logic [PTR_W-1:0] start_ptr,
  output logic [CNT_W-1:0] fill,
  output logic [PTR_W-1:0] wr_slot,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             ovf_hit,
  output logic             ovf_bit
);
  logic locked;
  logic evt_live;
  logic full;
  logic [PTR_W-1:0] start_nxt;
  logic [CNT_W-1:0] fill_nxt;

  assign locked    = err_flag & ovf_bit;
  assign evt_live  = evt_valid & ~clear & ~locked;
  assign full      = (32'(fill) == DEPTH);
  assign push_ok   = evt_live & ~full;
  assign ovf_hit   = evt_live & full;
  assign pop_ok    = pop_req & ~clear & (fill > CNT_W'(1));
  assign wr_slot   = PTR_W'(ring_slot(32'(start_ptr), 32'(fill), DEPTH));
  assign start_nxt = PTR_W'(ring_slot(32'(start_ptr), 1, DEPTH));
  assign fill_nxt  = fill + CNT_W'(push_ok) - CNT_W'(pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_ptr <= '0;
      fill      <= '0;
    end else if (clear) begin
      start_ptr <= '0;
      fill      <= '0;
    end else begin
      if (pop_ok) start_ptr <= start_nxt;
      fill <= fill_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_bit <= 1'b0;
    else if (ovf_hit) ovf_bit <= 1'b1;
    else if (err_clr) ovf_bit <= 1'b0;
  end

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill) <= DEPTH);
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !pop_ok |=> 32'(fill) == 32'($past(fill)) + 1);
  assert_drop_sets_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> ovf_bit);
  assert_locked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && ovf_bit |-> !push_ok && !ovf_hit);
  assert_bit_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !ovf_hit |=> !ovf_bit);
  assert_short_pop_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && fill <= CNT_W'(1) && !push_ok && !clear |=> $stable(fill) && $stable(start_ptr));
  assert_pop_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> 32'(start_ptr) == (32'($past(start_ptr)) + 1) % DEPTH);
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !push_ok && !pop_ok && !clear |=> $stable(start_ptr) && $stable(fill));
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> fill == '0 && start_ptr == '0);
  assert_push_pop_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && pop_ok |=> $stable(fill));
endmodule

// File: rtl/keyevt_store.sv
`timescale 1ns/1ps
module keyevt_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] wslot,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] rslot_a,
  input  logic [PTR_W-1:0] rslot_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cells[g] <= '0;
      else if (we && wslot == PTR_W'(g))    cells[g] <= wdata;
    end
  end

  assign rdata_a = cells[rslot_a];
  assign rdata_b = cells[rslot_b];
endmodule

// File: rtl/keyevt_readout.sv
`timescale 1ns/1ps
module keyevt_readout
  import keyevt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int OFF_W = PTR_W + 1
) (
  input  logic [PTR_W-1:0]      start_ptr,
  input  logic [CNT_W-1:0]      fill,
  input  logic [OFF_W-1:0]      peek_off,
  output logic [PTR_W-1:0]      pop_slot,
  output logic [PTR_W-1:0]      peek_slot,
  input  logic [KEY_BYTE_W-1:0] pop_raw,
  input  logic [KEY_BYTE_W-1:0] peek_raw,
  output logic [KEY_BYTE_W-1:0] pop_data,
  output logic [KEY_BYTE_W-1:0] peek_data
);
  logic pop_empty;
  logic peek_past;

  assign pop_slot  = PTR_W'(ring_slot(32'(start_ptr), 1, DEPTH));
  assign peek_slot = PTR_W'(ring_slot(32'(start_ptr), 32'(peek_off), DEPTH));
  assign pop_empty = (fill <= CNT_W'(1));
  assign peek_past = (32'(peek_off) >= 32'(fill));
  assign pop_data  = pop_empty ? '0 : pop_raw;
  assign peek_data = peek_past ? '0 : peek_raw;
endmodule

// File: rtl/keyevt_queue.sv
`timescale 1ns/1ps
module keyevt_queue
  import keyevt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int OFF_W = PTR_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  evt_valid,
  input  logic [KEY_CODE_W-1:0] evt_code,
  input  logic                  evt_release,
  input  logic                  err_flag,
  input  logic                  err_clr,
  input  logic                  pop_req,
  output logic [KEY_BYTE_W-1:0] pop_data,
  input  logic [OFF_W-1:0]      peek_off,
  output logic [KEY_BYTE_W-1:0] peek_data,
  output logic                  key_seen,
  output logic                  ovf_seen,
  output logic                  ovf_bit,
  output logic [CNT_W-1:0]      fill_level
);
  logic [PTR_W-1:0]      start_ptr;
  logic [CNT_W-1:0]      fill;
  logic [PTR_W-1:0]      wr_slot;
  logic [PTR_W-1:0]      pop_slot;
  logic [PTR_W-1:0]      peek_slot;
  logic                  push_ok;
  logic                  pop_ok;
  logic                  ovf_hit;
  logic [KEY_BYTE_W-1:0] evt_byte;
  logic [KEY_BYTE_W-1:0] pop_raw;
  logic [KEY_BYTE_W-1:0] peek_raw;

  assign evt_byte = pack_key(evt_code, evt_release);

  keyevt_ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .evt_valid(evt_valid),
    .pop_req(pop_req), .err_flag(err_flag), .err_clr(err_clr),
    .start_ptr(start_ptr), .fill(fill), .wr_slot(wr_slot),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovf_hit(ovf_hit), .ovf_bit(ovf_bit)
  );

  keyevt_store #(.DEPTH(DEPTH), .WIDTH(KEY_BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(push_ok), .wslot(wr_slot), .wdata(evt_byte),
    .rslot_a(pop_slot), .rslot_b(peek_slot), .rdata_a(pop_raw), .rdata_b(peek_raw)
  );

  keyevt_readout #(.DEPTH(DEPTH)) u_read (
    .start_ptr(start_ptr), .fill(fill), .peek_off(peek_off),
    .pop_slot(pop_slot), .peek_slot(peek_slot),
    .pop_raw(pop_raw), .peek_raw(peek_raw),
    .pop_data(pop_data), .peek_data(peek_data)
  );

  assign key_seen   = push_ok;
  assign ovf_seen   = ovf_hit;
  assign fill_level = fill;

  assert_short_pop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(1) |-> pop_data == '0);
  assert_pulses_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_seen && ovf_seen));
  assert_clear_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !key_seen && !ovf_seen);
endmodule

// File: tb/keyevt_queue_bench.sv
`timescale 1ns/1ps
module keyevt_queue_bench;
  localparam int DEPTH = 16;
  localparam int OFF_W = $clog2(DEPTH) + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, evt_valid = 1'b0, evt_release = 1'b0;
  logic [6:0] evt_code = '0;
  logic err_flag = 1'b0, err_clr = 1'b0, pop_req = 1'b0;
  logic [OFF_W-1:0] peek_off = '0;
  logic [7:0] pop_data, peek_data;
  logic key_seen, ovf_seen, ovf_bit;
  logic [CNT_W-1:0] fill_level;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int mq [DEPTH];
  int ms = 0, mc = 0;
  bit movf = 1'b0;

  always #4 clk = ~clk;

  keyevt_queue #(.DEPTH(DEPTH)) u_keyevt_queue (
    .clk(clk), .rst_n(rst_n), .clear(clear), .evt_valid(evt_valid),
    .evt_code(evt_code), .evt_release(evt_release), .err_flag(err_flag),
    .err_clr(err_clr), .pop_req(pop_req), .pop_data(pop_data),
    .peek_off(peek_off), .peek_data(peek_data), .key_seen(key_seen),
    .ovf_seen(ovf_seen), .ovf_bit(ovf_bit), .fill_level(fill_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, combinational outputs checked before the edge
  task automatic step(input bit ev, input int code, input bit rel, input bit pop,
                      input bit clr, input bit ef, input bit ec, input string tag);
    bit lock, acc, drop;
    int exp_pop;
    @(negedge clk);
    evt_valid = ev; evt_code = 7'(code); evt_release = rel;
    pop_req = pop; clear = clr; err_flag = ef; err_clr = ec;
    #1;
    lock = ef && movf;
    acc  = ev && !clr && !lock && (mc < DEPTH);
    drop = ev && !clr && !lock && (mc == DEPTH);
    exp_pop = (mc <= 1) ? 0 : mq[(ms + 1) % DEPTH];
    chk({tag, " key_seen"}, int'(key_seen), int'(acc));
    chk({tag, " ovf_seen"}, int'(ovf_seen), int'(drop));
    if (pop) chk({tag, " pop_data"}, int'(pop_data), exp_pop);
    @(posedge clk);
    if (clr) begin
      ms = 0; mc = 0;
    end else begin
      if (acc) mq[(ms + mc) % DEPTH] = (int'(rel) * 128) + (code % 128);
      if (pop && mc > 1) begin ms = (ms + 1) % DEPTH; mc--; end
      if (acc) mc++;
    end
    if (drop) movf = 1'b1;
    else if (ec) movf = 1'b0;
  endtask

  task automatic idle_in;
    @(negedge clk);
    evt_valid = 0; pop_req = 0; clear = 0; err_flag = 0; err_clr = 0;
  endtask

  // all offsets, including every one at or past the fill level
  task automatic sweep(input string tag);
    idle_in();
    #1;
    chk({tag, " fill_level"}, int'(fill_level), mc);
    chk({tag, " ovf_bit"}, int'(ovf_bit), int'(movf));
    for (int off = 0; off < 2 * DEPTH; off++) begin
      peek_off = OFF_W'(off);
      #0.25;
      chk($sformatf("%s R8 peek off=%0d", tag, off), int'(peek_data),
          (off < mc) ? mq[(ms + off) % DEPTH] : 0);
    end
    peek_off = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mq[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset pop_data", int'(pop_data), 0);
    rst_n = 1'b1;
    sweep("R11 reset");

    // fill to capacity with mixed press/release codes
    for (int i = 0; i < DEPTH; i++)
      step(1, (i * 37 + 5) % 128, i[0], 0, 0, 0, 0, "R1 R2 push");
    sweep("R1 R2 full");

    // overflow drop
    step(1, 7'h2a, 1, 0, 0, 0, 0, "R3 drop");
    sweep("R3 after drop");
    step(1, 7'h11, 0, 0, 0, 0, 0, "R3 drop again");

    // consuming reads from full
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, 0, "R7 pop");
    sweep("R7 after pops");

    // lockout: error flag and sticky bit both set
    step(1, 7'h55, 1, 0, 0, 1, 0, "R4 locked push");
    step(1, 7'h56, 0, 1, 0, 1, 0, "R4 locked push with pop");
    sweep("R4 locked");

    // sticky bit release, then accepted again
    step(0, 0, 0, 0, 0, 0, 1, "R5 err_clr");
    sweep("R5 cleared");
    step(1, 7'h3c, 1, 0, 0, 1, 0, "R5 accepted after clear");
    sweep("R5 accept");

    // simultaneous push and pop across several wraps
    for (int i = 0; i < 40; i++) begin
      step(1, (i * 11 + 3) % 128, i[1], 1, 0, 0, 0, "R10 push+pop");
      if (i % 8 == 7) sweep("R10 wrap");
    end

    // drain to one entry, then short pops
    while (mc > 1) step(0, 0, 0, 1, 0, 0, 0, "R7 drain");
    step(0, 0, 0, 1, 0, 0, 0, "R6 pop at one");
    sweep("R6 one entry");

    // clear beats push and pop in the same cycle
    step(1, 7'h01, 0, 0, 0, 0, 0, "R2 push");
    step(1, 7'h02, 1, 1, 1, 0, 0, "R9 clear");
    sweep("R9 cleared");
    step(0, 0, 0, 1, 0, 0, 0, "R6 pop empty");
    step(1, 7'h7f, 1, 1, 0, 0, 0, "R6 push+pop at zero");
    step(1, 7'h40, 0, 1, 0, 0, 0, "R6 push+pop at one");
    step(1, 7'h41, 1, 1, 0, 0, 0, "R10 push+pop at two");
    sweep("R10 small");

    // overflow and err_clr in the same cycle: overflow wins
    while (mc < DEPTH) step(1, mc + 20, 0, 0, 0, 0, 0, "R2 refill");
    step(1, 7'h33, 0, 0, 0, 0, 1, "R5 drop with clr");
    sweep("R5 overflow wins");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule